// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits beside a two-port shared memory and watches both access ports. Each port has an enable, a write strobe and a word address. When both ports are enabled on the same word, the block picks one port to proceed. It flags the other port with an active-low busy signal and removes that port's write strobe before it reaches the memory array. The winner is the port whose enable and address were already settled when the other port arrived. If both arrive in the same clock cycle, the left port wins. The winner keeps the grant until the collision ends.

A mode pin selects one of two roles. In master mode the block drives both busy outputs itself. In slave mode both busy outputs are held deasserted, and a separate active-low busy input on each side blocks only that side's writes. This lets an external arbiter in another device control the gating. All pins are plain control signals, so there is no handshake and no back-pressure. Results are combinational from the current port inputs and a one-cycle registered history of both ports.

Top module: `dpca_collision_arb`

## Requirements
- R1: When the two ports are not both enabled, or are enabled on different addresses, both `left_busy_n` and `right_busy_n` are 1 in the same cycle.
- R2: When a collision first appears and exactly one port held the same enabled address in the previous cycle, that earlier port wins and the other port's busy output goes to 0.
- R3: `left_busy_n` and `right_busy_n` are never 0 together. A collision that appears on both ports in the same cycle, with neither settled beforehand, sets `right_busy_n` to 0 (left wins).
- R4: A port whose busy output is 0 in master mode has its memory write strobe at 0. A port that is not busy has its memory write strobe equal to its enable AND its write strobe.
- R5: Once granted, the winner keeps the grant on every following cycle in which the collision continues, even when the arrival rule alone would now pick the other port.
- R6: The busy indication is released in the same cycle that either enable drops or the two addresses differ.
- R7: With `master_mode` = 0, both busy outputs are 1. A 0 on a side's busy input forces that side's memory write strobe to 0, and a 1 lets it follow enable AND write.
- R8: While `rst_n` is 0 and both ports are idle, both busy outputs are 1 and both memory write strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the history registers |
| master_mode | input | 1 | 1: drive busy outputs; 0: take busy from the inputs |
| left_en | input | 1 | Left port enable, active high |
| left_we | input | 1 | Left port write strobe, active high |
| left_addr | input | ADDR_W | Left port word address |
| right_en | input | 1 | Right port enable, active high |
| right_we | input | 1 | Right port write strobe, active high |
| right_addr | input | ADDR_W | Right port word address |
| left_busy_in_n | input | 1 | Slave mode: active-low write inhibit for the left port |
| right_busy_in_n | input | 1 | Slave mode: active-low write inhibit for the right port |
| left_busy_n | output | 1 | Active-low busy flag to the left port |
| right_busy_n | output | 1 | Active-low busy flag to the right port |
| left_mem_we | output | 1 | Gated write strobe to the array, left port |
| right_mem_we | output | 1 | Gated write strobe to the array, right port |

## Verification
Every output depends combinationally on the current port inputs and on history registered at the previous rising edge. Each result is therefore due in the same cycle as its stimulus, and arrival order only takes effect at the edge after an input settles. The bench changes inputs on the falling edge and samples one nanosecond later, before the next rising edge records the history. The vector table is ordered so that each row relies on the history that the rows before it leave behind.

// File: rtl/dpca_pkg.sv
package dpca_pkg;
  localparam int DEF_ADDR_W = 13;
  localparam int NUM_PORTS  = 2;

  typedef enum logic {
    WIN_LEFT  = 1'b0,
    WIN_RIGHT = 1'b1
  } winner_e;
endpackage

// File: rtl/dpca_port_track.sv
module dpca_port_track #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output logic              settled
);
  logic              en_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      en_q   <= en;
      addr_q <= addr;
    end
  end

  // port held this enabled address across the previous edge
  assign settled = en && en_q && (addr == addr_q);
endmodule

// File: rtl/dpca_resolver.sv
module dpca_resolver
  import dpca_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic collide,
  input  logic left_settled,
  input  logic right_settled,
  output logic left_lose,
  output logic right_lose
);
  logic    coll_q;
  winner_e win_q;
  winner_e win;

  always_comb begin
    if (coll_q && collide)
      win = win_q;
    else if (left_settled && !right_settled)
      win = WIN_LEFT;
    else if (right_settled && !left_settled)
      win = WIN_RIGHT;
    else
      win = WIN_LEFT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      coll_q <= 1'b0;
      win_q  <= WIN_LEFT;
    end else begin
      coll_q <= collide;
      win_q  <= win;
    end
  end

  assign left_lose  = collide && (win == WIN_RIGHT);
  assign right_lose = collide && (win == WIN_LEFT);
endmodule

// File: rtl/dpca_port_gate.sv
module dpca_port_gate (
  input  logic master_mode,
  input  logic lose,
  input  logic busy_in_n,
  input  logic en,
  input  logic we,
  output logic busy_out_n,
  output logic mem_we
);
  logic inhibit;

  assign inhibit    = master_mode ? lose : !busy_in_n;
  assign busy_out_n = master_mode ? !lose : 1'b1;
  assign mem_we     = en && we && !inhibit;
endmodule

// File: rtl/dpca_collision_arb.sv
module dpca_collision_arb
  import dpca_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_mode,
  input  logic              left_en,
  input  logic              left_we,
  input  logic [ADDR_W-1:0] left_addr,
  input  logic              right_en,
  input  logic              right_we,
  input  logic [ADDR_W-1:0] right_addr,
  input  logic              left_busy_in_n,
  input  logic              right_busy_in_n,
  output logic              left_busy_n,
  output logic              right_busy_n,
  output logic              left_mem_we,
  output logic              right_mem_we
);
  logic              en_a     [NUM_PORTS];
  logic              we_a     [NUM_PORTS];
  logic [ADDR_W-1:0] addr_a   [NUM_PORTS];
  logic              bin_a    [NUM_PORTS];
  logic              settled_a[NUM_PORTS];
  logic              lose_a   [NUM_PORTS];
  logic              bout_a   [NUM_PORTS];
  logic              mwe_a    [NUM_PORTS];
  logic              collide;

  assign en_a[0]   = left_en;
  assign en_a[1]   = right_en;
  assign we_a[0]   = left_we;
  assign we_a[1]   = right_we;
  assign addr_a[0] = left_addr;
  assign addr_a[1] = right_addr;
  assign bin_a[0]  = left_busy_in_n;
  assign bin_a[1]  = right_busy_in_n;

  assign collide = left_en && right_en && (left_addr == right_addr);

  for (genvar gi = 0; gi < NUM_PORTS; gi++) begin : g_port
    dpca_port_track #(.ADDR_W(ADDR_W)) u_track (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en_a[gi]),
      .addr    (addr_a[gi]),
      .settled (settled_a[gi])
    );

    dpca_port_gate u_gate (
      .master_mode (master_mode),
      .lose        (lose_a[gi]),
      .busy_in_n   (bin_a[gi]),
      .en          (en_a[gi]),
      .we          (we_a[gi]),
      .busy_out_n  (bout_a[gi]),
      .mem_we      (mwe_a[gi])
    );
  end

  dpca_resolver u_res (
    .clk           (clk),
    .rst_n         (rst_n),
    .collide       (collide),
    .left_settled  (settled_a[0]),
    .right_settled (settled_a[1]),
    .left_lose     (lose_a[0]),
    .right_lose    (lose_a[1])
  );

  assign left_busy_n  = bout_a[0];
  assign right_busy_n = bout_a[1];
  assign left_mem_we  = mwe_a[0];
  assign right_mem_we = mwe_a[1];
endmodule

// File: rtl/dpca_checker.sv
module dpca_checker #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              master_mode,
  input logic              left_en,
  input logic              left_we,
  input logic [ADDR_W-1:0] left_addr,
  input logic              right_en,
  input logic              right_we,
  input logic [ADDR_W-1:0] right_addr,
  input logic              left_busy_in_n,
  input logic              right_busy_in_n,
  input logic              left_busy_n,
  input logic              right_busy_n,
  input logic              left_mem_we,
  input logic              right_mem_we
);
  logic same_word;
  assign same_word = left_en && right_en && (left_addr == right_addr);

  AST_BUSY_ONLY_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!left_busy_n || !right_busy_n) |-> same_word); // R1
  AST_NEVER_BOTH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !(!left_busy_n && !right_busy_n)); // R3
  AST_LEFT_WRITE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && !left_busy_n) |-> !left_mem_we); // R4
  AST_RIGHT_WRITE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && !right_busy_n) |-> !right_mem_we); // R4
  AST_RIGHT_LOSS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && $past(master_mode) && $past(!right_busy_n) && same_word) |-> !right_busy_n); // R5
  AST_LEFT_LOSS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && $past(master_mode) && $past(!left_busy_n) && same_word) |-> !left_busy_n); // R5
  AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !master_mode |-> (left_busy_n && right_busy_n)); // R7
  AST_SLAVE_LEFT_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_mode && !left_busy_in_n) |-> !left_mem_we); // R7
  AST_SLAVE_RIGHT_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_mode && !right_busy_in_n) |-> !right_mem_we); // R7
endmodule

bind dpca_collision_arb dpca_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .master_mode     (master_mode),
  .left_en         (left_en),
  .left_we         (left_we),
  .left_addr       (left_addr),
  .right_en        (right_en),
  .right_we        (right_we),
  .right_addr      (right_addr),
  .left_busy_in_n  (left_busy_in_n),
  .right_busy_in_n (right_busy_in_n),
  .left_busy_n     (left_busy_n),
  .right_busy_n    (right_busy_n),
  .left_mem_we     (left_mem_we),
  .right_mem_we    (right_mem_we)
);

// File: tb/sim_dpca_collision_arb.sv
`timescale 1ns/1ps
module sim_dpca_collision_arb;
  localparam int AW = 13;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          master_mode;
  logic          left_en, left_we, right_en, right_we;
  logic [AW-1:0] left_addr, right_addr;
  logic          left_busy_in_n, right_busy_in_n;
  logic          left_busy_n, right_busy_n, left_mem_we, right_mem_we;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  dpca_collision_arb #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
    .left_en(left_en), .left_we(left_we), .left_addr(left_addr),
    .right_en(right_en), .right_we(right_we), .right_addr(right_addr),
    .left_busy_in_n(left_busy_in_n), .right_busy_in_n(right_busy_in_n),
    .left_busy_n(left_busy_n), .right_busy_n(right_busy_n),
    .left_mem_we(left_mem_we), .right_mem_we(right_mem_we)
  );

  // expected = {left_busy_n, right_busy_n, left_mem_we, right_mem_we}
  typedef struct packed {
    logic          m;
    logic          le;
    logic          lw;
    logic [AW-1:0] la;
    logic          re;
    logic          rw;
    logic [AW-1:0] ra;
    logic          bil;
    logic          bir;
    logic [3:0]    exp;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 1'b0, 13'd0, 1'b0, 1'b0, 13'd0, 1'b1, 1'b1, 4'b1100, 4'd1}, // idle
    '{1'b1, 1'b1, 1'b1, 13'd5, 1'b1, 1'b1, 13'd7, 1'b1, 1'b1, 4'b1111, 4'd1}, // differ
    '{1'b1, 1'b1, 1'b1, 13'd5, 1'b1, 1'b1, 13'd5, 1'b1, 1'b1, 4'b1010, 4'd2}, // left first
    '{1'b1, 1'b1, 1'b1, 13'd5, 1'b1, 1'b1, 13'd5, 1'b1, 1'b1, 4'b1010, 4'd4}, // write gated
    '{1'b1, 1'b1, 1'b1, 13'd5, 1'b1, 1'b1, 13'd6, 1'b1, 1'b1, 4'b1111, 4'd6}, // diverge
    '{1'b1, 1'b0, 1'b0, 13'd0, 1'b0, 1'b0, 13'd0, 1'b1, 1'b1, 4'b1100, 4'd1},
    '{1'b1, 1'b0, 1'b0, 13'd0, 1'b1, 1'b0, 13'd9, 1'b1, 1'b1, 4'b1100, 4'd1},
    '{1'b1, 1'b1, 1'b1, 13'd9, 1'b1, 1'b0, 13'd9, 1'b1, 1'b1, 4'b0100, 4'd2}, // right first
    '{1'b1, 1'b1, 1'b1, 13'd9, 1'b1, 1'b0, 13'd9, 1'b1, 1'b1, 4'b0100, 4'd5}, // hold vs tie
    '{1'b1, 1'b0, 1'b1, 13'd9, 1'b1, 1'b0, 13'd9, 1'b1, 1'b1, 4'b1100, 4'd6}, // enable drop
    '{1'b1, 1'b0, 1'b0, 13'd0, 1'b0, 1'b0, 13'd0, 1'b1, 1'b1, 4'b1100, 4'd1},
    '{1'b1, 1'b1, 1'b1, 13'd3, 1'b1, 1'b1, 13'd3, 1'b1, 1'b1, 4'b1010, 4'd3}, // same cycle
    '{1'b1, 1'b1, 1'b1, 13'd3, 1'b1, 1'b1, 13'd3, 1'b1, 1'b1, 4'b1010, 4'd5},
    '{1'b1, 1'b1, 1'b1, 13'd4, 1'b1, 1'b1, 13'd3, 1'b1, 1'b1, 4'b1111, 4'd6},
    '{1'b0, 1'b1, 1'b1, 13'd3, 1'b1, 1'b1, 13'd3, 1'b1, 1'b1, 4'b1111, 4'd7}, // slave pass
    '{1'b0, 1'b1, 1'b1, 13'd3, 1'b1, 1'b1, 13'd3, 1'b0, 1'b1, 4'b1101, 4'd7},
    '{1'b0, 1'b1, 1'b1, 13'd3, 1'b1, 1'b1, 13'd3, 1'b1, 1'b0, 4'b1110, 4'd7},
    '{1'b1, 1'b0, 1'b0, 13'd0, 1'b0, 1'b0, 13'd0, 1'b1, 1'b1, 4'b1100, 4'd1}
  };

  task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got {bl,br,wl,wr}=%b expected %b", req, got, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    master_mode = v.m;  left_en = v.le;  left_we = v.lw;  left_addr = v.la;
    right_en = v.re;  right_we = v.rw;  right_addr = v.ra;
    left_busy_in_n = v.bil;  right_busy_in_n = v.bir;
  endtask

  function automatic logic [3:0] outs();
    return {left_busy_n, right_busy_n, left_mem_we, right_mem_we};
  endfunction

  function automatic vec_t mk(input logic le, input logic [AW-1:0] la,
                              input logic re, input logic [AW-1:0] ra);
    vec_t v;
    v = '0;
    v.m = 1'b1; v.le = le; v.lw = 1'b1; v.la = la;
    v.re = re; v.rw = 1'b1; v.ra = ra; v.bil = 1'b1; v.bir = 1'b1;
    return v;
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got %0d cycles expected under 5000", cycles);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    drive(VECS[0]);
    repeat (3) @(negedge clk);
    #1 check("R8", outs(), 4'b1100);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i]);
      #1 check($sformatf("R%0d row %0d", VECS[i].req, i), outs(), VECS[i].exp);
    end

    // R2 / R5: right settled, left arrives; right keeps grant while collision lasts
    @(negedge clk); drive(mk(1'b0, 13'd0, 1'b1, 13'h1FFF));
    #1 check("R1 right alone", outs(), 4'b1101);
    @(negedge clk); drive(mk(1'b1, 13'h1FFF, 1'b1, 13'h1FFF));
    #1 check("R2 right earlier", outs(), 4'b0101);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      #1 check("R5 right holds", outs(), 4'b0101);
    end
    // R6: release on right enable drop
    @(negedge clk); drive(mk(1'b1, 13'h1FFF, 1'b0, 13'h1FFF));
    #1 check("R6 right drop", outs(), 4'b1110);
    // R3: re-collide in same cycle after both idle, left wins
    @(negedge clk); drive(mk(1'b0, 13'd0, 1'b0, 13'd0));
    @(negedge clk); drive(mk(1'b1, 13'd0, 1'b1, 13'd0));
    #1 check("R3 tie address 0", outs(), 4'b1010);
    // R8: reset in mid-collision clears history, tie again gives left
    @(negedge clk); rst_n = 1'b0; drive(mk(1'b0, 13'd0, 1'b0, 13'd0));
    #1 check("R8 reset idle", outs(), 4'b1100);
    @(negedge clk); rst_n = 1'b1;
    finish_run();
  end
endmodule